// File: doc/BRIEF.md
# Bus Grant Arbitration Controller

This block sits on the bus-master side of a processor and lets an external master take the system bus. The external master's request and acknowledge arrive asynchronously. Each one passes through its own synchronizer chain before the state machine uses it. The processor supplies its address strobe and a one-cycle pulse that marks the start of a bus cycle. These two signals define a window: a cycle has begun but the address strobe has not yet appeared. A request that arrives inside this window gets its grant one clock later than usual.

The block drives a bus grant output and a float enable. The float enable is the control that lets the address, data and control buses go to high impedance. It is also combined with the address strobe into a release indication, which is true only while the float enable is set and the strobe is low. A strap input selects the acknowledge scheme:
- In three-wire mode the external master answers the grant with an acknowledge.
- In two-wire mode the acknowledge input is ignored, and the request alone holds the bus.

Every signal is active-high inside the block. Pin polarity is set by parameters at the synchronizer input.

The machine has four states:
- `ST_IDLE`: the processor owns the bus.
- `ST_HOLD`: a request arrived inside the window and the grant waits one clock.
- `ST_GRANT`: the grant and the float enable are both asserted.
- `ST_OWNED`: the acknowledge has been seen, the grant is withdrawn and the buses stay floated.

Transitions:
- idle→grant: request seen, window closed.
- idle→hold: request seen, window open.
- hold→grant: request still present.
- hold→idle: request withdrawn.
- grant→owned: three-wire mode, acknowledge seen.
- grant→idle: request gone, and no acknowledge in three-wire mode.
- owned→idle: acknowledge negated.

Top module: `bus_grant_arbiter`

## Requirements
- R1: During and after reset, with no request present, bus_grant_o, float_en_o and bus_hiz_o are all 0.
- R2: When the window is closed, a request raised at the pin is followed by bus_grant_o = 1 and float_en_o = 1 after the third rising edge, and not before it. This is two synchronizer edges plus one state edge.
- R3: A request that reaches the machine while the window is open (opened by a cyc_start_i pulse, address strobe low) asserts the grant one edge later, after the fourth rising edge.
- R4: The window opens on the edge that samples cyc_start_i = 1 and closes on the edge that samples addr_strobe_i = 1. Once it has closed, a request gets the R2 timing again.
- R5: A request that is withdrawn while the machine is in the hold state returns the machine to idle, and the grant is never asserted.
- R6: In three-wire mode (two_wire_i = 0), an acknowledge raised at the pin while granted clears bus_grant_o after the third rising edge, and float_en_o stays 1.
- R7: In three-wire mode, float_en_o falls after the third rising edge following the fall of the acknowledge pin.
- R8: In two-wire mode (two_wire_i = 1), the acknowledge pin has no effect. The grant and the float enable stay 1 while the request is held, and both fall after the third rising edge following the request's fall.
- R9: bus_hiz_o is 1 exactly when float_en_o is 1 and addr_strobe_i is 0.
- R10: In three-wire mode, a request dropped after the grant and before any acknowledge clears both the grant and the float enable after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Asynchronous bus request from the external master |
| bus_ack_i | input | 1 | Asynchronous grant acknowledge from the external master |
| addr_strobe_i | input | 1 | Processor address strobe (synchronous, active high) |
| cyc_start_i | input | 1 | One-cycle pulse when the processor begins a bus cycle |
| two_wire_i | input | 1 | Strap: 1 selects two-wire, 0 selects three-wire |
| bus_grant_o | output | 1 | Bus grant to the external master |
| float_en_o | output | 1 | Three-state control for the processor's buses |
| bus_hiz_o | output | 1 | Buses actually released (float enable and strobe low) |

## Verification
The bench measures the grant latency inside the start-to-strobe window and just after the window has closed. A design that ignores the window grants one edge early. A design that never clears the window delays every later grant. It sends a one-cycle request into the window: a design that does not check the request in the hold state produces a stray grant. It raises the acknowledge in two-wire mode, which a design that does not mask it would answer by dropping the grant. It also checks that the float enable outlives the grant until the acknowledge falls, and that a request abandoned without an acknowledge releases the bus.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_GRANT = 2'd2,
        ST_OWNED = 2'd3
    } arb_state_e;

    localparam int SYNC_IDX_REQ = 0;
    localparam int SYNC_IDX_ACK = 1;
    localparam int SYNC_LANES   = 2;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INVERT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             level;

    // Normalise pin polarity before the first flop so the chain is active-high.
    assign level = async_i ^ INVERT;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= level;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], level};
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/arb_window.sv
module arb_window (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic addr_strobe_i,
    output logic open_o
);
    logic open_q;

    // The strobe wins over a start pulse sampled on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              open_q <= 1'b0;
        else if (addr_strobe_i)  open_q <= 1'b0;
        else if (cyc_start_i)    open_q <= 1'b1;
    end

    assign open_o = open_q;

    a_r4_strobe_closes: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_i |=> !open_o);

    a_r4_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_i && !addr_strobe_i) |=> open_o);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_i,
    input  logic ack_s_i,
    input  logic window_i,
    input  logic two_wire_i,
    output logic grant_o,
    output logic float_o
);
    arb_state_e state_q, state_d;
    logic       ack_v;

    // Two-wire operation sees the acknowledge as permanently negated.
    assign ack_v = ack_s_i & ~two_wire_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_s_i) state_d = window_i ? ST_HOLD : ST_GRANT;
            end
            ST_HOLD: begin
                state_d = req_s_i ? ST_GRANT : ST_IDLE;
            end
            ST_GRANT: begin
                if (ack_v)         state_d = ST_OWNED;
                else if (!req_s_i) state_d = ST_IDLE;
            end
            ST_OWNED: begin
                if (!ack_v) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_o = 1'b0;
        float_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_HOLD:  ;
            ST_GRANT: begin
                grant_o = 1'b1;
                float_o = 1'b1;
            end
            ST_OWNED: float_o = 1'b1;
            default:  ;
        endcase
    end

    a_r2_prompt_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_s_i && !window_i) |=> grant_o);

    a_r3_window_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_s_i && window_i) |=> (!grant_o && state_q == ST_HOLD));

    a_r5_withdraw_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !req_s_i) |=> (!grant_o && !float_o));

    a_r6_ack_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT && ack_s_i && !two_wire_i) |=> (!grant_o && float_o));

    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && !ack_s_i) |=> !float_o);

    a_r8_two_wire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (two_wire_i && grant_o && req_s_i) |=> grant_o);

    a_r8_two_wire_no_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (two_wire_i && state_q != ST_OWNED) |=> state_q != ST_OWNED);

    a_r10_abandon_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT && !req_s_i && !ack_s_i) |=> (!grant_o && !float_o));

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter bit REQ_ACTIVE_LOW = 1'b0,
    parameter bit ACK_ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_i,
    input  logic bus_ack_i,
    input  logic addr_strobe_i,
    input  logic cyc_start_i,
    input  logic two_wire_i,
    output logic bus_grant_o,
    output logic float_en_o,
    output logic bus_hiz_o
);
    localparam logic [SYNC_LANES-1:0] POL_MASK = {ACK_ACTIVE_LOW, REQ_ACTIVE_LOW};

    logic [SYNC_LANES-1:0] raw_pins;
    logic [SYNC_LANES-1:0] synced;
    logic                  window;

    assign raw_pins[SYNC_IDX_REQ] = bus_req_i;
    assign raw_pins[SYNC_IDX_ACK] = bus_ack_i;

    arb_sync #(
        .WIDTH  (SYNC_LANES),
        .STAGES (SYNC_STAGES),
        .INVERT (POL_MASK)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (synced)
    );

    arb_window u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start_i   (cyc_start_i),
        .addr_strobe_i (addr_strobe_i),
        .open_o        (window)
    );

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s_i    (synced[SYNC_IDX_REQ]),
        .ack_s_i    (synced[SYNC_IDX_ACK]),
        .window_i   (window),
        .two_wire_i (two_wire_i),
        .grant_o    (bus_grant_o),
        .float_o    (float_en_o)
    );

    assign bus_hiz_o = float_en_o & ~addr_strobe_i;

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!bus_grant_o && !float_en_o));

    a_r9_strobe_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_i |-> !bus_hiz_o);

endmodule

// File: tb/bus_grant_arbiter_bench.sv
module bus_grant_arbiter_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req_i = 1'b0;
    logic bus_ack_i = 1'b0;
    logic addr_strobe_i = 1'b0;
    logic cyc_start_i = 1'b0;
    logic two_wire_i = 1'b0;
    logic bus_grant_o, float_en_o, bus_hiz_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        bit    g;
        bit    f;
        bit    h;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bus_grant_arbiter u_bus_grant_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req_i     (bus_req_i),
        .bus_ack_i     (bus_ack_i),
        .addr_strobe_i (addr_strobe_i),
        .cyc_start_i   (cyc_start_i),
        .two_wire_i    (two_wire_i),
        .bus_grant_o   (bus_grant_o),
        .float_en_o    (float_en_o),
        .bus_hiz_o     (bus_hiz_o)
    );

    task automatic compare(bit g, bit f, bit h, string tag);
        n_checks++;
        if (bus_grant_o !== g || float_en_o !== f || bus_hiz_o !== h) begin
            n_fail++;
            $display("FAIL %s cycle %0d: grant/float/hiz = %0b%0b%0b expected %0b%0b%0b",
                     tag, cyc, bus_grant_o, float_en_o, bus_hiz_o, g, f, h);
        end
    endtask

    // Driver side: queue an expectation d cycles after the current one.
    task automatic expect_at(int d, bit g, bit f, bit h, string tag);
        exp_t e;
        e.at = cyc + d; e.g = g; e.f = f; e.h = h; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops and compares expectations that fall due on this cycle.
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at == cyc) begin
                compare(sb_q[i].g, sb_q[i].f, sb_q[i].h, sb_q[i].tag);
                sb_q.delete(i);
            end else if (sb_q[i].at < cyc) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)",
                         sb_q[i].tag, sb_q[i].at, cyc);
                sb_q.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(2);
        compare(1'b0, 1'b0, 1'b0, "R1 in reset");
        tick(2);
        rst_n = 1'b1;
        expect_at(1, 1'b0, 1'b0, 1'b0, "R1 after reset");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R1 after reset");
        tick(4);

        // R2 / R9 / R6 / R7: three-wire handover
        bus_req_i = 1'b1;
        expect_at(2, 1'b0, 1'b0, 1'b0, "R2 not early");
        expect_at(3, 1'b1, 1'b1, 1'b1, "R2 grant");
        tick(5);
        addr_strobe_i = 1'b1;
        expect_at(1, 1'b1, 1'b1, 1'b0, "R9 strobe high");
        tick(2);
        bus_ack_i = 1'b1;
        bus_req_i = 1'b0;
        expect_at(2, 1'b1, 1'b1, 1'b0, "R6 before ack seen");
        expect_at(3, 1'b0, 1'b1, 1'b0, "R6 ack drops grant");
        tick(5);
        addr_strobe_i = 1'b0;
        expect_at(1, 1'b0, 1'b1, 1'b1, "R9 strobe low");
        tick(2);
        bus_ack_i = 1'b0;
        expect_at(2, 1'b0, 1'b1, 1'b1, "R7 float held");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R7 release");
        tick(6);

        // R3: request inside the window, then R10: abandon without ack
        cyc_start_i = 1'b1;
        bus_req_i = 1'b1;
        expect_at(3, 1'b0, 1'b0, 1'b0, "R3 delayed");
        expect_at(4, 1'b1, 1'b1, 1'b1, "R3 grant");
        tick(1);
        cyc_start_i = 1'b0;
        tick(5);
        bus_req_i = 1'b0;
        expect_at(2, 1'b1, 1'b1, 1'b1, "R10 still granted");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R10 release");
        tick(5);
        addr_strobe_i = 1'b1;
        tick(1);
        addr_strobe_i = 1'b0;
        tick(2);

        // R4: window closed by the strobe, normal timing again
        cyc_start_i = 1'b1;
        tick(1);
        cyc_start_i = 1'b0;
        addr_strobe_i = 1'b1;
        tick(1);
        addr_strobe_i = 1'b0;
        tick(2);
        bus_req_i = 1'b1;
        expect_at(3, 1'b1, 1'b1, 1'b1, "R4 closed window");
        tick(5);
        bus_req_i = 1'b0;
        expect_at(3, 1'b0, 1'b0, 1'b0, "R4 release");
        tick(5);

        // R5: one-cycle request inside the window
        cyc_start_i = 1'b1;
        bus_req_i = 1'b1;
        expect_at(3, 1'b0, 1'b0, 1'b0, "R5 no grant");
        expect_at(4, 1'b0, 1'b0, 1'b0, "R5 no grant");
        expect_at(5, 1'b0, 1'b0, 1'b0, "R5 no grant");
        tick(1);
        cyc_start_i = 1'b0;
        bus_req_i = 1'b0;
        tick(6);
        addr_strobe_i = 1'b1;
        tick(1);
        addr_strobe_i = 1'b0;
        tick(2);

        // R8: two-wire mode ignores the acknowledge
        two_wire_i = 1'b1;
        tick(1);
        bus_req_i = 1'b1;
        expect_at(3, 1'b1, 1'b1, 1'b1, "R8 grant");
        tick(4);
        bus_ack_i = 1'b1;
        expect_at(3, 1'b1, 1'b1, 1'b1, "R8 ack ignored");
        expect_at(5, 1'b1, 1'b1, 1'b1, "R8 ack ignored");
        tick(6);
        bus_req_i = 1'b0;
        expect_at(2, 1'b1, 1'b1, 1'b1, "R8 held");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R8 release");
        tick(5);
        bus_ack_i = 1'b0;
        two_wire_i = 1'b0;
        tick(4);

        finished = 1'b1;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule